// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

The block collects up to 32 event inputs into one interrupt request line. Each event input is watched for a rising edge. An edge latches a bit in a status register, and the bit stays there until software clears it. A mask register, with one bit per source, decides which latched bits may drive the request line. The line is high whenever a latched bit is not masked.

A processor reaches the block over a plain 32-bit register bus with a write strobe, a byte address, write data and combinational read data. Software never needs a read-modify-write. Status bits are raised through one write port and dropped through another. Mask bits likewise have separate set and clear ports. Software can also raise any event itself, which is handy for testing a handler or deferring work.

A typical assignment of sources is:

| Source | Bit |
|---|---|
| link up | 4 |
| link down | 5 |
| receive DMA done | 13 |
| transmit DMA done | 16 |
| management done | 23 |
| management error | 24 |

The block itself treats all sources alike.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, status (read at byte offset 0x00) is all zeros, mask (read at 0x0C) is all ones, and `irq_o` is low.
- R2: A rising edge on `evt_i[k]` sets status bit k at the next clock edge. An input that stays high does not set the bit again once it has been cleared.
- R3: Writing to offset 0x04 sets every status bit whose write-data bit is one. Zero bits leave status unchanged.
- R4: Writing to offset 0x08 clears every status bit whose write-data bit is one. Zero bits leave status unchanged.
- R5: When a rising edge on a source arrives in the same cycle as a clear write to that bit, the bit ends up set.
- R6: Writing to offset 0x10 sets mask bits (masks those sources). Writing to offset 0x14 clears mask bits (unmasks them). Zero bits have no effect.
- R7: Offsets 0x00 and 0x0C are read-only: writes to them change nothing. Reads of 0x04, 0x08, 0x10, 0x14 and any other offset return zero.
- R8: `irq_o` is a register. In the cycle after a clock edge, it equals the OR over all bits of (status AND NOT mask) as held before that edge. So it follows a status or mask change with one cycle of delay.
- R9: Masking a source does not stop its status bit from latching or from reading back at 0x00.
- R10: Writing all ones to 0x10 and then all ones to 0x08 leaves `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| evt_i | input | N_SRC | Event inputs, level or pulse, rising edge latched |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check several rules on every cycle:
- a detected edge always lands in status, even against a clear;
- clear and mask writes take effect on exactly the written bits;
- writes to the read-only offsets leave status untouched;
- the request line is low after any cycle with nothing pending or with everything masked.

Only the bench's scenarios can show the rest, and it checks them against a behavioural model on every clock:
- that a held-high input is not re-latched;
- the exact one-cycle delay of the request line;
- read-back values at each offset;
- the mask-all then clear-all sequence.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned REG_ADDR_W = 5;

  // Byte offsets of the register bank.
  localparam logic [REG_ADDR_W-1:0] OFS_STATUS   = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_SET      = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_CLEAR    = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK     = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK_SET = 5'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK_CLR = 5'h14;

  // Conventional source positions used by the surrounding system.
  localparam int unsigned SRC_LINK_UP   = 4;
  localparam int unsigned SRC_LINK_DOWN = 5;
  localparam int unsigned SRC_RX_DONE   = 13;
  localparam int unsigned SRC_TX_DONE   = 16;
  localparam int unsigned SRC_MGMT_DONE = 23;
  localparam int unsigned SRC_MGMT_ERR  = 24;

  typedef struct packed {
    logic st_set;
    logic st_clr;
    logic mk_set;
    logic mk_clr;
  } wr_strobe_t;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_STATUS,
    RSEL_MASK
  } rsel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  output logic [N_SRC-1:0] rise_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
      end else begin
        prev_q <= evt_i[g];
      end
    end

    assign rise_o[g] = evt_i[g] & ~prev_q;
  end

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = REG_ADDR_W
) (
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output wr_strobe_t        strobe_o,
  output rsel_e             rsel_o
);

  logic hit_set, hit_clr, hit_mset, hit_mclr, hit_st, hit_mk;

  always_comb begin
    hit_st   = (bus_addr_i == ADDR_W'(OFS_STATUS));
    hit_set  = (bus_addr_i == ADDR_W'(OFS_SET));
    hit_clr  = (bus_addr_i == ADDR_W'(OFS_CLEAR));
    hit_mk   = (bus_addr_i == ADDR_W'(OFS_MASK));
    hit_mset = (bus_addr_i == ADDR_W'(OFS_MASK_SET));
    hit_mclr = (bus_addr_i == ADDR_W'(OFS_MASK_CLR));

    strobe_o.st_set = bus_wr_i & hit_set;
    strobe_o.st_clr = bus_wr_i & hit_clr;
    strobe_o.mk_set = bus_wr_i & hit_mset;
    strobe_o.mk_clr = bus_wr_i & hit_mclr;

    if (hit_st) begin
      rsel_o = RSEL_STATUS;
    end else if (hit_mk) begin
      rsel_o = RSEL_MASK;
    end else begin
      rsel_o = RSEL_NONE;
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rise_i,
  input  wr_strobe_t       strobe_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o
);

  logic [N_SRC-1:0] status_q, status_d;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic [N_SRC-1:0] set_vec, clr_vec, mset_vec, mclr_vec;
  logic             status_en, mask_en;

  always_comb begin
    set_vec  = strobe_i.st_set ? wdata_i : '0;
    clr_vec  = strobe_i.st_clr ? wdata_i : '0;
    mset_vec = strobe_i.mk_set ? wdata_i : '0;
    mclr_vec = strobe_i.mk_clr ? wdata_i : '0;

    status_en = (|rise_i) | strobe_i.st_set | strobe_i.st_clr;
    mask_en   = strobe_i.mk_set | strobe_i.mk_clr;

    // Sets are applied after the clear, so an edge beats a clear.
    status_d = (status_q & ~clr_vec) | rise_i | set_vec;
    mask_d   = (mask_q & ~mclr_vec) | mset_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R2 / R5: every detected edge is visible in status one cycle later.
  p_edge_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((status_q & $past(rise_i)) == $past(rise_i)))
    else $error("edge not latched");

  p_edge_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i.st_clr && |(rise_i & wdata_i)) |=>
      ((status_q & $past(rise_i & wdata_i)) == $past(rise_i & wdata_i)))
    else $error("clear overrode edge");

  // R4: cleared bits without a concurrent edge are zero afterwards.
  p_clear_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i.st_clr |=> ((status_q & $past(wdata_i & ~rise_i)) == '0))
    else $error("clear write ineffective");

  // R6: mask set and mask clear land on exactly the written ones.
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i.mk_set |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)))
    else $error("mask set ineffective");

  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i.mk_clr |=> ((mask_q & $past(wdata_i)) == '0))
    else $error("mask clear ineffective");

  p_mask_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe_i.mk_set || strobe_i.mk_clr) && wdata_i == '0) |=> $stable(mask_q))
    else $error("zero mask write changed mask");

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = REG_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic             rst_sync_n;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] mask;
  wr_strobe_t       strobe;
  rsel_e            rsel;
  logic             irq_q, irq_d;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_rise_detect #(.N_SRC(N_SRC)) u_rise (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt_i  (evt_i),
    .rise_o (rise)
  );

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .strobe_o   (strobe),
    .rsel_o     (rsel)
  );

  irq_status_bank #(.N_SRC(N_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rise_i   (rise),
    .strobe_i (strobe),
    .wdata_i  (bus_wdata_i[N_SRC-1:0]),
    .status_o (status),
    .mask_o   (mask)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (rsel)
      RSEL_STATUS: bus_rdata_o[N_SRC-1:0] = status;
      RSEL_MASK:   bus_rdata_o[N_SRC-1:0] = mask;
      default:     bus_rdata_o = '0;
    endcase
  end

  always_comb begin
    irq_d = |(status & ~mask);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R8: nothing pending in one cycle means a quiet line in the next.
  p_quiet_line_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((status & ~mask) == '0) |=> !irq_o)
    else $error("irq high with nothing pending");

  // R10: a fully masked bank never requests.
  p_all_masked_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&mask) |=> !irq_o)
    else $error("irq high while fully masked");

  // R7: writing the read-only status offset leaves status alone.
  p_ro_status_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFS_STATUS) && rise == '0) |=> $stable(status))
    else $error("status offset writable");

  p_ro_mask_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFS_MASK)) |=> $stable(mask))
    else $error("mask offset writable");

endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ev;
  logic          wr;
  logic [4:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  logic [31:0] m_st, m_mk, m_prev;
  logic        m_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_status_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (ev),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a == 5'h00) return m_st;
    if (a == 5'h0C) return m_mk;
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: update the model at the edge, compare after the falling edge.
  task automatic tick();
    logic [31:0] rise, sset, sclr, mset, mclr;
    @(posedge clk);
    rise = ev & ~m_prev;
    sset = (wr && addr == 5'h04) ? wdata : 32'h0;
    sclr = (wr && addr == 5'h08) ? wdata : 32'h0;
    mset = (wr && addr == 5'h10) ? wdata : 32'h0;
    mclr = (wr && addr == 5'h14) ? wdata : 32'h0;
    m_irq  = |(m_st & ~m_mk);
    m_st   = (m_st & ~sclr) | rise | sset;
    m_mk   = (m_mk & ~mclr) | mset;
    m_prev = ev;
    @(negedge clk);
    check("R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
    check("R7 rdata vs model", rdata, m_read(addr));
  endtask

  task automatic bus_w(input logic [4:0] a, input logic [31:0] d);
    addr = a; wr = 1'b1; wdata = d;
    tick();
    wr = 1'b0; wdata = 32'h0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev = '0; wr = 1'b0; addr = 5'h00; wdata = 32'h0;
    m_st = 32'h0; m_mk = 32'hFFFF_FFFF; m_prev = 32'h0; m_irq = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(5'h00, 32'h0, "R1 status after reset");
    rd_chk(5'h0C, 32'hFFFF_FFFF, "R1 mask after reset");
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R10 mask all then clear all
    bus_w(5'h10, 32'hFFFF_FFFF);
    bus_w(5'h08, 32'hFFFF_FFFF);
    tick(); tick();
    check("R10 irq low", {31'b0, irq}, 32'h0);

    // R2 / R8 pulse on bit 4 with bit 4 unmasked
    bus_w(5'h14, 32'h0000_0010);
    ev = 32'h0000_0010;
    tick();
    ev = '0;
    rd_chk(5'h00, 32'h0000_0010, "R2 pulse latched");
    check("R8 irq not yet", {31'b0, irq}, 32'h0);
    tick();
    check("R8 irq one cycle later", {31'b0, irq}, 32'h1);

    // R2 held level is not re-latched after a clear
    ev = 32'h0000_0020;
    tick();
    rd_chk(5'h00, 32'h0000_0030, "R2 level edge latched");
    bus_w(5'h08, 32'h0000_0030);
    tick(); tick();
    rd_chk(5'h00, 32'h0, "R2 held level not re-set");
    check("R4 irq drops after clear", {31'b0, irq}, 32'h0);
    ev = '0;
    tick();

    // R5 edge and clear in the same cycle
    ev = 32'h0000_2000;
    bus_w(5'h08, 32'h0000_2000);
    ev = '0;
    rd_chk(5'h00, 32'h0000_2000, "R5 set wins over clear");
    bus_w(5'h08, 32'h0000_2000);
    rd_chk(5'h00, 32'h0, "R4 clear");

    // R3 software set, zero writes
    bus_w(5'h04, 32'h0001_0000);
    rd_chk(5'h00, 32'h0001_0000, "R3 software set");
    bus_w(5'h08, 32'h0);
    rd_chk(5'h00, 32'h0001_0000, "R4 zero clear no effect");
    bus_w(5'h04, 32'h0);
    rd_chk(5'h00, 32'h0001_0000, "R3 zero set no effect");

    // R6 / R9 masking
    tick();
    check("R9 masked bit no irq", {31'b0, irq}, 32'h0);
    bus_w(5'h14, 32'h0001_0000);
    tick();
    check("R6 unmask raises irq", {31'b0, irq}, 32'h1);
    bus_w(5'h10, 32'h0001_0000);
    tick();
    check("R6 mask drops irq", {31'b0, irq}, 32'h0);
    rd_chk(5'h00, 32'h0001_0000, "R9 masked status readable");
    rd_chk(5'h0C, 32'hFFFF_FFEF, "R6 mask value");
    bus_w(5'h14, 32'h0);
    rd_chk(5'h0C, 32'hFFFF_FFEF, "R6 zero mask clear no effect");

    // R7 read-only and write-only offsets
    bus_w(5'h00, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'h0001_0000, "R7 status read-only");
    bus_w(5'h0C, 32'h0);
    rd_chk(5'h0C, 32'hFFFF_FFEF, "R7 mask read-only");
    rd_chk(5'h04, 32'h0, "R7 set offset reads zero");
    rd_chk(5'h14, 32'h0, "R7 mask clear offset reads zero");
    rd_chk(5'h18, 32'h0, "R7 unmapped reads zero");

    // Mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      ev = $urandom & $urandom & $urandom;
      wr = ($urandom % 3) == 0;
      case ($urandom % 8)
        0: addr = 5'h00;
        1: addr = 5'h04;
        2: addr = 5'h08;
        3: addr = 5'h0C;
        4: addr = 5'h10;
        5: addr = 5'h14;
        6: addr = 5'h18;
        default: addr = 5'h08;
      endcase
      wdata = $urandom & $urandom;
      tick();
    end
    wr = 1'b0; ev = '0;
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule